// File: doc/BRIEF.md
# Linear-Phase FIR Filter with Bit-Serial Pre-Combining and Partial-Sum Table

This block is a multiplier-free FIR filter for linear-phase coefficient sets. A new sample is written into a parallel delay line. The filter then walks the bits of every stored word, from the least significant bit upward. Mirrored taps carry coefficients of equal magnitude. Each mirrored pair is folded into a single bit stream by a one-bit serial adder, which becomes a serial subtractor when the filter is antisymmetric. The folded bits address a partial-sum table that holds one sum for every subset of the half-coefficient set, so the address is only about half as wide as the tap count.

Each table word is shifted by the current bit weight and added into an accumulator. The most significant step is subtracted instead, because it carries the sign. The folded value of a pair is one bit wider than an input word, so a result takes DATA_W+1 compute cycles. In the final step every operand's sign bit is repeated as a sign extension. When the tap count is odd, the centre tap has no partner and its bits go straight to the top address bit.

The result is kept at full precision. It appears with a one-cycle valid pulse and holds until the next result. While a result is being computed, the filter accepts no new sample.

Top module: `sym_da_fir`

## Requirements
- R1: After reset, out_valid and out_data are 0 and every delay-line word is zero, so the first outputs see an all-zero history.
- R2: With ANTI=0, each result equals the exact sum over the pairs k of c[k]*(x[n-k]+x[n-(NTAPS-1-k)]), plus the centre term when NTAPS is odd. Here x[n] is the newest accepted sample, and c[k] is the signed field COEFS[k*COEF_W +: COEF_W], with k=0 pairing the newest and the oldest tap.
- R3: With ANTI=1, each pair contributes c[k]*(x[n-k]-x[n-(NTAPS-1-k)]) instead, with the same field positions.
- R4: out_valid is a single-cycle pulse. It is high after the (DATA_W+1)th rising edge that follows the edge accepting the sample.
- R5: in_valid is ignored while a result is being computed. A word offered in that window never enters the delay line.
- R6: out_data changes only together with an out_valid pulse and otherwise holds its last value.
- R7: Inputs at the extremes (-2^(DATA_W-1) and 2^(DATA_W-1)-1) give exact results, including pair sums and differences that need DATA_W+1 bits.
- R8: For an odd NTAPS, the centre coefficient c[(NTAPS-1)/2] weights x[n-(NTAPS-1)/2] alone.
- R9: When in_valid is held high, a new sample is accepted on the edge right after the out_valid edge, one result every DATA_W+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Offers in_data; taken only while idle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | OUT_W | Signed full-precision result |

## Verification
The assertions assume that reset is applied at the start and that in_valid is a plain level sampled at the clock, with no protocol of its own. They make no assumption about how often in_valid is raised while the filter is busy. The stimulus holds in_valid high through busy windows, pulses it in the middle of a computation, and also offers isolated samples, so every acceptance case is exercised. Input words stay within the signed DATA_W range, and the coefficient sets fed to the two instances fit in COEF_W bits.

// File: rtl/sym_da_fir.sv
module sym_da_fir #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int NTAPS = 7,
  parameter bit ANTI = 1'b0,
  parameter logic [COEF_W*((NTAPS+1)/2)-1:0] COEFS = {8'd90, 8'd40, 8'hF5, 8'd3},
  parameter int OUT_W = DATA_W + COEF_W + $clog2((NTAPS+1)/2) + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_data
);
  localparam int HALF  = (NTAPS + 1) / 2;
  localparam int NPAIR = NTAPS / 2;
  localparam int ODD   = NTAPS % 2;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int LUT_W = COEF_W + $clog2(HALF) + 1;
  localparam int LUT_N = 1 << HALF;

  function automatic logic signed [LUT_W-1:0] lut_entry(input int addr);
    logic signed [LUT_W-1:0] s;
    logic signed [COEF_W-1:0] c;
    s = '0;
    for (int k = 0; k < HALF; k++) begin
      c = COEFS[k*COEF_W +: COEF_W];
      if (addr[k]) s = s + LUT_W'(c);
    end
    return s;
  endfunction

  logic signed [LUT_W-1:0]  lut [LUT_N];
  logic signed [DATA_W-1:0] taps [NTAPS];
  logic                     busy;
  logic [CNT_W-1:0]         cnt;
  logic [NPAIR-1:0]         cy, nc, psum;
  logic signed [OUT_W-1:0]  acc, part, contrib;
  logic [NTAPS-1:0]         tbit;
  logic [HALF-1:0]          addr;
  logic                     last;
  logic [IDX_W-1:0]         bidx;

  for (genvar a = 0; a < LUT_N; a++) begin : g_lut
    assign lut[a] = lut_entry(a);
  end

  assign last = (cnt == CNT_W'(DATA_W));
  assign bidx = last ? IDX_W'(DATA_W - 1) : cnt[IDX_W-1:0];

  for (genvar k = 0; k < NTAPS; k++) begin : g_bit
    assign tbit[k] = taps[k][bidx];
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pre
    logic a_b, b_b;
    assign a_b = tbit[p];
    assign b_b = tbit[NTAPS-1-p] ^ ANTI;
    assign psum[p] = a_b ^ b_b ^ cy[p];
    assign nc[p] = (a_b & b_b) | (a_b & cy[p]) | (b_b & cy[p]);
  end

  assign addr[NPAIR-1:0] = psum;
  if (ODD != 0) begin : g_ctr
    assign addr[HALF-1] = tbit[NPAIR];
  end

  assign part    = OUT_W'(lut[addr]) <<< cnt;
  assign contrib = last ? -part : part;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      cy        <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int k = 0; k < NTAPS; k++) taps[k] <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          for (int k = NTAPS - 1; k > 0; k--) taps[k] <= taps[k-1];
          taps[0] <= in_data;
          busy <= 1'b1;
          cnt  <= '0;
          acc  <= '0;
          cy   <= {NPAIR{ANTI}};
        end
      end else begin
        cy <= nc;
        if (last) begin
          out_data  <= acc + contrib;
          out_valid <= 1'b1;
          busy      <= 1'b0;
        end else begin
          acc <= acc + contrib;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  logic [CNT_W:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (in_valid && !busy) age <= 1;
    else if (busy) age <= age + 1'b1;
  end

  // R4
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> age == (CNT_W+1)'(DATA_W + 2));
  // R5
  ignore_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy && in_valid |=> $stable(taps[0]));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
endmodule

// File: tb/sym_da_fir_test.sv
`timescale 1ns/1ps
module sym_da_fir_test;
  localparam int DW = 8;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic va, vb;
  logic signed [19:0] oa, ob;
  int nchk = 0, nerr = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  sym_da_fir #(.DATA_W(8), .COEF_W(8), .NTAPS(7), .ANTI(1'b0),
    .COEFS({8'd90, 8'd40, 8'hF5, 8'd3})) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(va), .out_data(oa));

  sym_da_fir #(.DATA_W(8), .COEF_W(8), .NTAPS(6), .ANTI(1'b1),
    .COEFS({8'd71, 8'd23, 8'hFB})) uut_anti (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(vb), .out_data(ob));

  longint ha [7] = '{3, -11, 40, 90, 40, -11, 3};
  longint hb [6] = '{-5, 23, 71, -71, -23, 5};
  longint hist [7];
  bit mbusy = 0, ev = 0;
  int mleft = 0;
  longint pa = 0, pb = 0, ya = 0, yb = 0;

  always @(posedge clk) begin
    if (rst) begin
      mbusy = 0; ev = 0; ya = 0; yb = 0;
      for (int k = 0; k < 7; k++) hist[k] = 0;
    end else begin
      ev = 0;
      if (mbusy) begin
        mleft--;
        if (mleft == 0) begin mbusy = 0; ev = 1; ya = pa; yb = pb; end
      end else if (in_valid) begin
        for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'(in_data);
        pa = 0; pb = 0;
        for (int k = 0; k < 7; k++) pa += ha[k] * hist[k];
        for (int k = 0; k < 6; k++) pb += hb[k] * hist[k];
        mbusy = 1; mleft = DW + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(va == ev, "R4", longint'(va), longint'(ev));
      check(vb == ev, "R4", longint'(vb), longint'(ev));
      if (ev) begin
        check(longint'(oa) == ya, "R2", longint'(oa), ya);
        check(longint'(ob) == yb, "R3", longint'(ob), yb);
      end else begin
        check(longint'(oa) == ya, "R6", longint'(oa), ya);
        check(longint'(ob) == yb, "R6", longint'(ob), yb);
      end
    end
  end

  task automatic send(input int v);
    @(negedge clk); in_valid = 1'b1; in_data = DW'(v);
    @(negedge clk); in_valid = 1'b0;
    repeat (DW + 1) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog [%s] actual=timeout expected=finish", phase);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(va == 1'b0 && vb == 1'b0, "R1", longint'(va | vb), 0);
    check(oa == 0 && ob == 0, "R1", longint'(oa), 0);
    rst = 1'b0;
    // R2 R3 R8: impulse walks through every tap, centre tap included
    phase = "R8";
    send(1);
    for (int i = 0; i < 8; i++) send(0);
    // step input
    phase = "R2";
    for (int i = 0; i < 9; i++) send(37);
    // R7: extremes and alternating extremes
    phase = "R7";
    for (int i = 0; i < 8; i++) send(-128);
    for (int i = 0; i < 8; i++) send(127);
    for (int i = 0; i < 10; i++) send((i % 2 == 1) ? -128 : 127);
    // random samples
    phase = "R3";
    for (int i = 0; i < 60; i++) send(int'($urandom_range(255)) - 128);
    // R5: words offered mid-computation are dropped
    phase = "R5";
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = DW'(int'($urandom_range(255)) - 128);
      @(negedge clk); in_valid = 1'b0;
      repeat (3) @(negedge clk);
      in_valid = 1'b1; in_data = 8'sd99;
      @(negedge clk); in_valid = 1'b0;
      repeat (DW + 2) @(negedge clk);
    end
    // R9: valid held high, back-to-back acceptance
    phase = "R9";
    @(negedge clk); in_valid = 1'b1;
    for (int i = 0; i < 200; i++) begin
      in_data = DW'(int'($urandom_range(255)) - 128);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (2 * DW + 4) @(negedge clk);
    finish_run();
  end
endmodule